// File: doc/BRIEF.md
# Pointer-Queue Page Fill DMA

This block streams incoming sample bytes into memory pages whose base addresses software supplies ahead of time. Software pushes page base pointers into a small on-chip queue. The engine takes one pointer at a time and writes consecutive bytes of a fixed-size page through a plain byte write port. When a page is full, it continues straight into the next queued page, with no interrupt between pages.

The engine raises an interrupt only after the last page has been filled and no further pointer is waiting. Software can add pointers at any time, including while a page is being filled. This lets a driver keep the queue topped up and handle one interrupt per batch of pages rather than one per page. Status outputs show queue occupancy, whether a page is in progress, a sticky flag for pushes that were lost, and a count of samples that were dropped because no page was available.

The write port is combinational from the sample input. A sample that arrives in a given cycle is presented on the write port in that same cycle.

Top module: `qdma_engine`

## Requirements
- R1: After reset, `fifoCount` is 0, `busy`, `irq`, `pushOverflow` and `memWrEn` are 0, and `underrunCount` is 0.
- R2: A push with `pushValid` high while the queue holds fewer than FIFO_DEPTH pointers is stored. `fifoCount` shows the new occupancy from the following cycle.
- R3: A push while the queue is full, in a cycle where no pointer is taken, is dropped. It sets `pushOverflow`, which stays high until a cycle with `ovfClear` high and no new overflow.
- R4: A sample arriving while idle, with at least one pointer queued, is written in the same cycle to the oldest pointer plus 0. That pointer leaves the queue, and `busy` is high from the next cycle.
- R5: The k-th byte of a page (k counted from 0) is written to page base + k, with `memWrData` equal to `sampleData`.
- R6: The byte at offset PAGE_BYTES-1 takes the next queued pointer at the same clock edge. The next sample is then written to that pointer plus 0, with no idle cycle between pages.
- R7: If the byte at offset PAGE_BYTES-1 is written while the queue is empty, `busy` falls and `irq` rises on the next cycle. `irq` stays high until a cycle with `irqAck` high and no new completion.
- R8: A pointer pushed while a page is in progress is used after the pointers queued before it, in push order.
- R9: A sample arriving while idle with an empty queue writes nothing and adds 1 to `underrunCount`. The count saturates at 2^CNT_W-1.
- R10: `memWrEn` is high exactly in the cycles where `sampleValid` is high and either a page is in progress or a pointer is queued. Cycles without a sample do not advance the page offset.
- R11: A push while the queue is full is accepted, without setting `pushOverflow`, when a pointer is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Push a page pointer this cycle |
| pushAddr | input | ADDR_W | Page base address being pushed |
| sampleValid | input | 1 | A sample byte is present this cycle |
| sampleData | input | 8 | Sample byte |
| irqAck | input | 1 | Clear the completion interrupt |
| ovfClear | input | 1 | Clear the push overflow flag |
| memWrEn | output | 1 | Byte write strobe |
| memWrAddr | output | ADDR_W | Byte write address |
| memWrData | output | 8 | Byte write data |
| busy | output | 1 | A page is in progress |
| irq | output | 1 | Sticky queue-exhausted interrupt |
| pushOverflow | output | 1 | Sticky lost-push flag |
| fifoCount | output | $clog2(FIFO_DEPTH+1) | Queued pointer count |
| underrunCount | output | CNT_W | Saturating dropped-sample count |

## Verification
The bench builds the engine with PAGE_BYTES=8, FIFO_DEPTH=4 and CNT_W=4. Short pages let several page-to-page handovers and queue drains happen within a few dozen samples. A four-entry queue makes the full and overflow cases, including a push that meets a pop on a full queue, easy to reach. A 4-bit underrun counter saturates after fifteen dropped samples, so its ceiling is exercised in a directed step. The random phase then mixes pushes, sample gaps, acknowledges and clears, so that a page end coincides with pushes and an empty queue in many combinations.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  // Strobes from the sequencer to the datapath for one clock cycle.
  typedef struct packed {
    logic push;        // store pushAddr in the queue
    logic pop;         // retire the oldest pointer
    logic loadPage;    // latch the oldest pointer as the active page base
    logic incOff;      // advance the byte offset
    logic clrOff;      // return the byte offset to zero
    logic selHead;     // address from the queue head (idle) instead of page base
    logic underrunInc; // count one dropped sample
  } qdma_ctrl_t;
endpackage

// File: rtl/qdma_datapath.sv
module qdma_datapath
  import qdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  qdma_ctrl_t                         ctrl,
  input  logic [ADDR_W-1:0]                  pushAddr,
  input  logic [7:0]                         sampleData,
  output logic [ADDR_W-1:0]                  memWrAddr,
  output logic [7:0]                         memWrData,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]    fifoCount,
  output logic                               fifoEmpty,
  output logic                               fifoFull,
  output logic                               lastByte,
  output logic [CNT_W-1:0]                   underrunCount
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_F = $clog2(FIFO_DEPTH + 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);
  localparam logic [CNT_F-1:0] FULL_CNT = CNT_F'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] UND_MAX  = '1;

  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_F-1:0]  count;
  logic [ADDR_W-1:0] slotView [FIFO_DEPTH];
  logic [ADDR_W-1:0] head;
  logic [ADDR_W-1:0] pageBase;
  logic [OFF_W-1:0]  offset;
  logic [CNT_W-1:0]  undCnt;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // One register per queue slot.
  for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_slot
    logic [ADDR_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (ctrl.push && wrPtr == PTR_W'(i)) slotQ <= pushAddr;
    end
    assign slotView[i] = slotQ;
  end

  assign head = slotView[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctrl.push) wrPtr <= bumpPtr(wrPtr);
      if (ctrl.pop)  rdPtr <= bumpPtr(rdPtr);
      case ({ctrl.push, ctrl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase <= '0;
      offset   <= '0;
      undCnt   <= '0;
    end else begin
      if (ctrl.loadPage) pageBase <= head;
      if (ctrl.clrOff)      offset <= '0;
      else if (ctrl.incOff) offset <= offset + 1'b1;
      if (ctrl.underrunInc && undCnt != UND_MAX) undCnt <= undCnt + 1'b1;
    end
  end

  assign memWrAddr     = (ctrl.selHead ? head : pageBase) + ADDR_W'(offset);
  assign memWrData     = sampleData;
  assign fifoCount     = count;
  assign fifoEmpty     = (count == '0);
  assign fifoFull      = (count == FULL_CNT);
  assign lastByte      = (offset == LAST_OFF);
  assign underrunCount = undCnt;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R2
  AST_COUNT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.push && !ctrl.pop) |=> (count == $past(count) + 1'b1)); // R2
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pop |-> !fifoEmpty); // R6
  AST_IDLE_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.selHead |-> (offset == '0)); // R4
  AST_UNDERRUN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.underrunInc && undCnt != UND_MAX) |=> (undCnt == $past(undCnt) + 1'b1)); // R9
endmodule

// File: rtl/qdma_control.sv
module qdma_control
  import qdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushValid,
  input  logic       sampleValid,
  input  logic       irqAck,
  input  logic       ovfClear,
  input  logic       fifoEmpty,
  input  logic       fifoFull,
  input  logic       lastByte,
  output qdma_ctrl_t ctrl,
  output logic       memWrEn,
  output logic       busy,
  output logic       irq,
  output logic       pushOverflow
);
  logic active, wrNow, startPage, endPage, chainPage, drainPage, lostPush;

  always_comb begin
    active    = busy | ~fifoEmpty;
    wrNow     = sampleValid & active;
    startPage = wrNow & ~busy;
    endPage   = wrNow & busy & lastByte;
    chainPage = endPage & ~fifoEmpty;
    drainPage = endPage & fifoEmpty;

    ctrl             = '0;
    ctrl.selHead     = ~busy;
    ctrl.pop         = startPage | chainPage;
    ctrl.loadPage    = startPage | chainPage;
    ctrl.incOff      = wrNow & ~endPage;
    ctrl.clrOff      = endPage;
    ctrl.underrunInc = sampleValid & ~active;
    ctrl.push        = pushValid & (~fifoFull | ctrl.pop);
    lostPush         = pushValid & fifoFull & ~ctrl.pop;
  end

  assign memWrEn = wrNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= 1'b0;
      irq          <= 1'b0;
      pushOverflow <= 1'b0;
    end else begin
      if (startPage)      busy <= 1'b1;
      else if (drainPage) busy <= 1'b0;
      if (drainPage)      irq <= 1'b1;
      else if (irqAck)    irq <= 1'b0;
      if (lostPush)       pushOverflow <= 1'b1;
      else if (ovfClear)  pushOverflow <= 1'b0;
    end
  end

  AST_DRAIN_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && busy && lastByte && fifoEmpty) |=> (!busy && irq)); // R7
  AST_CHAIN_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && busy && lastByte && !fifoEmpty) |=> busy); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !busy && !fifoEmpty) |=> busy); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && fifoFull && !ctrl.pop) |=> pushOverflow); // R3
  AST_NO_WRITE_WHEN_DRY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && fifoEmpty) |-> !memWrEn); // R9
endmodule

// File: rtl/qdma_engine.sv
module qdma_engine
  import qdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            pushValid,
  input  logic [ADDR_W-1:0]               pushAddr,
  input  logic                            sampleValid,
  input  logic [7:0]                      sampleData,
  input  logic                            irqAck,
  input  logic                            ovfClear,
  output logic                            memWrEn,
  output logic [ADDR_W-1:0]               memWrAddr,
  output logic [7:0]                      memWrData,
  output logic                            busy,
  output logic                            irq,
  output logic                            pushOverflow,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifoCount,
  output logic [CNT_W-1:0]                underrunCount
);
  qdma_ctrl_t ctrl;
  logic fifoEmpty, fifoFull, lastByte;

  qdma_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .pushValid    (pushValid),
    .sampleValid  (sampleValid),
    .irqAck       (irqAck),
    .ovfClear     (ovfClear),
    .fifoEmpty    (fifoEmpty),
    .fifoFull     (fifoFull),
    .lastByte     (lastByte),
    .ctrl         (ctrl),
    .memWrEn      (memWrEn),
    .busy         (busy),
    .irq          (irq),
    .pushOverflow (pushOverflow)
  );

  qdma_datapath #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .pushAddr      (pushAddr),
    .sampleData    (sampleData),
    .memWrAddr     (memWrAddr),
    .memWrData     (memWrData),
    .fifoCount     (fifoCount),
    .fifoEmpty     (fifoEmpty),
    .fifoFull      (fifoFull),
    .lastByte      (lastByte),
    .underrunCount (underrunCount)
  );
endmodule

// File: tb/qdma_engine_bench.sv
`timescale 1ns/1ps
module qdma_engine_bench;
  localparam int AW = 32;
  localparam int PB = 8;
  localparam int FD = 4;
  localparam int CW = 4;
  localparam int UMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0, sampleValid = 1'b0, irqAck = 1'b0, ovfClear = 1'b0;
  logic [AW-1:0] pushAddr = '0;
  logic [7:0] sampleData = '0;
  logic memWrEn, busy, irq, pushOverflow;
  logic [AW-1:0] memWrAddr;
  logic [7:0] memWrData;
  logic [$clog2(FD+1)-1:0] fifoCount;
  logic [CW-1:0] underrunCount;

  always #5 clk = ~clk;

  qdma_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .FIFO_DEPTH(FD), .CNT_W(CW)) u_qdma_engine (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushAddr(pushAddr),
    .sampleValid(sampleValid), .sampleData(sampleData), .irqAck(irqAck),
    .ovfClear(ovfClear), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .busy(busy), .irq(irq), .pushOverflow(pushOverflow),
    .fifoCount(fifoCount), .underrunCount(underrunCount)
  );

  int tests = 0;
  int failed = 0;
  bit done = 1'b0;

  // Reference model state, built from the requirements.
  logic [AW-1:0] mq[$];
  bit mBusy = 0, mIrq = 0, mOvf = 0;
  logic [AW-1:0] mBase = '0;
  int mOff = 0;
  int mUnd = 0;
  logic [AW-1:0] obsAddr;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] expAddr(input bit b, input logic [AW-1:0] base,
                                            input logic [AW-1:0] hd, input int off);
    return (b ? base : hd) + AW'(off);
  endfunction

  task automatic step(input bit pv, input logic [AW-1:0] pa, input bit sv,
                      input logic [7:0] sd, input bit ia, input bit oc);
    bit active, wr, pop, drain, fullPre;
    logic [AW-1:0] ea;
    string atag;
    pushValid = pv; pushAddr = pa; sampleValid = sv; sampleData = sd;
    irqAck = ia; ovfClear = oc;
    #1;
    check(fifoCount == mq.size(), "R2 fifoCount", longint'(fifoCount), longint'(mq.size()));
    check(busy == mBusy, "R4 busy", longint'(busy), longint'(mBusy));
    check(irq == mIrq, "R7 irq", longint'(irq), longint'(mIrq));
    check(pushOverflow == mOvf, "R3 pushOverflow", longint'(pushOverflow), longint'(mOvf));
    check(underrunCount == mUnd, "R9 underrunCount", longint'(underrunCount), longint'(mUnd));
    active = mBusy || (mq.size() > 0);
    wr = sv && active;
    check(memWrEn == wr, "R10 memWrEn", longint'(memWrEn), longint'(wr));
    obsAddr = memWrAddr;
    if (wr) begin
      ea = expAddr(mBusy, mBase, mBusy ? mBase : mq[0], mOff);
      atag = !mBusy ? "R4 memWrAddr" : (mOff == 0 ? "R6 memWrAddr" : "R5 memWrAddr");
      check(memWrAddr == ea, atag, longint'(memWrAddr), longint'(ea));
      check(memWrData == sd, "R5 memWrData", longint'(memWrData), longint'(sd));
    end
    // Advance the model across the coming clock edge.
    pop = 0; drain = 0;
    fullPre = (mq.size() == FD);
    if (wr) begin
      if (!mBusy) begin
        mBase = mq[0]; pop = 1; mOff = 1; mBusy = 1;
      end else if (mOff == PB - 1) begin
        if (mq.size() > 0) begin mBase = mq[0]; pop = 1; mOff = 0; end
        else begin mBusy = 0; mOff = 0; drain = 1; end
      end else mOff++;
    end
    if (pop) void'(mq.pop_front());
    if (pv && (!fullPre || pop)) mq.push_back(pa);
    if (pv && fullPre && !pop) mOvf = 1; else if (oc) mOvf = 0;
    if (drain) mIrq = 1; else if (ia) mIrq = 0;
    if (sv && !active && mUnd != UMAX) mUnd++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic samples(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 1, 8'($urandom), 0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, '0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(fifoCount == 0, "R1 fifoCount", longint'(fifoCount), 0);
    check(!busy && !irq && !pushOverflow, "R1 flags", longint'({busy, irq, pushOverflow}), 0);
    check(underrunCount == 0, "R1 underrunCount", longint'(underrunCount), 0);
    check(!memWrEn, "R1 memWrEn", longint'(memWrEn), 0);

    // R9: samples with nothing queued are dropped and counted
    samples(3);
    check(underrunCount == 3, "R9 three drops", longint'(underrunCount), 3);

    // R2, R3: fill the queue, then one push too many
    step(1, 32'h0001_0000, 0, 0, 0, 0);
    step(1, 32'h0002_0000, 0, 0, 0, 0);
    step(1, 32'h0003_0000, 0, 0, 0, 0);
    step(1, 32'h0004_0000, 0, 0, 0, 0);
    step(1, 32'h0005_0000, 0, 0, 0, 0);
    check(pushOverflow == 1 && fifoCount == FD, "R3 overflow sticky",
          longint'({pushOverflow, fifoCount}), longint'({1'b1, 3'(FD)}));
    step(0, '0, 0, 0, 0, 1);
    check(pushOverflow == 0, "R3 cleared", longint'(pushOverflow), 0);

    // R4, R5, R6: first page, then seamless handover
    samples(PB);
    step(0, '0, 1, 8'h5A, 0, 0);
    check(obsAddr == 32'h0002_0000, "R6 next page base", longint'(obsAddr), 32'h0002_0000);
    // R10: a gap does not advance the offset
    idle(2);
    step(0, '0, 1, 8'h11, 0, 0);
    check(obsAddr == 32'h0002_0001, "R10 gap keeps offset", longint'(obsAddr), 32'h0002_0001);
    // R7: drain the rest, interrupt, acknowledge
    samples(3 * PB - 2);
    check(irq == 1 && busy == 0, "R7 drain irq", longint'({irq, busy}), 2'b10);
    step(0, '0, 0, 0, 1, 0);
    check(irq == 0, "R7 ack", longint'(irq), 0);

    // R8: pointer pushed during a page is used next
    step(1, 32'h00A0_0000, 0, 0, 0, 0);
    samples(3);
    step(1, 32'h00B0_0000, 1, 8'h22, 0, 0);
    samples(PB - 4);
    step(0, '0, 1, 8'h33, 0, 0);
    check(obsAddr == 32'h00B0_0000, "R8 push order", longint'(obsAddr), 32'h00B0_0000);

    // R11: full queue, push meets a pop at the page end
    for (int i = 0; i < FD; i++) step(1, 32'h0100_0000 + 32'(i << 12), 0, 0, 0, 0);
    samples(PB - 2);
    step(1, 32'h0200_0000, 1, 8'h44, 0, 0);
    check(fifoCount == FD && pushOverflow == 0, "R11 push with pop",
          longint'({pushOverflow, fifoCount}), longint'({1'b0, 3'(FD)}));

    // R9: saturate the dropped-sample counter
    samples((FD + 1) * PB + 20);
    check(underrunCount == UMAX, "R9 saturation", longint'(underrunCount), longint'(UMAX));
    step(0, '0, 0, 0, 1, 1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 6) == 0, $urandom & 32'hFFFF_F000, ($urandom % 4) != 0,
           8'($urandom), ($urandom % 20) == 0, ($urandom % 20) == 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule